// File: doc/BRIEF.md
# Rename Map with Pinned Zero Register

This block renames the registers of a small out-of-order core. It holds the map from logical to physical registers, the list of free physical registers, and the physical register file. Each rename request carries two source indices and one destination index. The block returns a physical tag for each source. For a destination that is written, it returns a freshly allocated physical tag and the tag that the destination held before. When an instruction commits, the core hands that old tag back to the free list.

Register 0 gets no special treatment when it is read. It is bound to physical entry 0, and a sequencer clears every entry of the physical register file after reset. An instruction that names register 0 as its destination loses its write flag at rename. Entry 0 is never allocated, written or freed. Reads of register 0 therefore go through the file like any other read and always return zero. Renames are held off until the clearing sequencer has finished.

Top module: `zero_pinned_rename`

## Requirements
- R1: After reset is released, `ready` stays low for exactly NUM_PHYS rising edges. During that time one physical entry per cycle is written with zero. `ready` goes high at the NUM_PHYS-th edge, and from then on every entry reads as zero until it is written.
- R2: While `ready` is low, `ren_grant` is low, so no rename allocates or changes the map.
- R3: At reset, logical register i maps to physical tag i for every i below NUM_LOGICAL. The free list holds tags NUM_LOGICAL to NUM_PHYS-1 and hands them out in ascending order. `free_full` is 1 and `free_empty` is 0.
- R4: A rename whose destination is logical 0 drives `ren_dst_we` to 0 and both `ren_tag_dst` and `ren_tag_old` to 0. It allocates no tag and leaves the map unchanged.
- R5: A granted rename with `ren_wr`=1 and a nonzero destination does three things in the same cycle. It drives `ren_dst_we`=1, gives `ren_tag_dst` as the free-list head, and gives `ren_tag_old` as the destination's current mapping. The map takes the new tag at the next edge. Sources in the same request see the map as it was before this update.
- R6: Logical source 0 always returns tag 0, and a read of tag 0 returns 0. A writeback to tag 0 is dropped.
- R7: A release on `rel_valid` appends `rel_tag` to the tail of the free list unless the tag is 0. A released tag 0 is discarded.
- R8: When the free list is empty, `free_empty` is 1. A rename that needs a tag is then refused (`ren_grant`=0). A rename that needs none is still granted.
- R9: A writeback to a nonzero tag after `ready` is stored, and the read port returns it at that tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready | output | 1 | Clearing walk finished; renames accepted |
| ren_valid | input | 1 | Rename request present |
| ren_src_a | input | LREG_W | First source logical index |
| ren_src_b | input | LREG_W | Second source logical index |
| ren_dst | input | LREG_W | Destination logical index |
| ren_wr | input | 1 | Instruction writes its destination |
| ren_grant | output | 1 | Request accepted this cycle |
| ren_tag_a | output | TAG_W | Physical tag of first source |
| ren_tag_b | output | TAG_W | Physical tag of second source |
| ren_tag_dst | output | TAG_W | Physical tag of destination |
| ren_tag_old | output | TAG_W | Previous mapping of destination |
| ren_dst_we | output | 1 | Write flag after the register-0 clear |
| rel_valid | input | 1 | Commit-time release present |
| rel_tag | input | TAG_W | Old tag to return to the free list |
| wb_valid | input | 1 | Writeback to register file |
| wb_tag | input | TAG_W | Writeback physical tag |
| wb_data | input | DATA_W | Writeback value |
| rd_tag | input | TAG_W | Read port physical tag |
| rd_data | output | DATA_W | Read port value |
| free_empty | output | 1 | Free list holds no tag |
| free_full | output | 1 | Free list holds every spare tag |

## Verification
A wrong map entry appears on the source tag outputs in the same cycle the affected index is presented. A wrong free-list pointer or count appears on the next allocated destination tag. It also shifts the cycle in which `free_empty` rises, and a leaked or duplicated tag changes the drain length by one. A missed clearing write, or a write that slips through to entry 0, appears as nonzero read data as soon as that tag is read after `ready` rises. An off-by-one in the walk moves the rising edge of `ready` by one cycle.

// File: rtl/zrm_pkg.sv
package zrm_pkg;
   typedef enum logic [0:0] {
      WALK_CLEAR = 1'b0,
      WALK_IDLE  = 1'b1
   } walk_state_t;

   function automatic int unsigned ring_next(input int unsigned ptr, input int unsigned depth);
      return (ptr == depth - 1) ? 0 : ptr + 1;
   endfunction
endpackage

// File: rtl/zrm_zero_walker.sv
module zrm_zero_walker #(
   parameter int NUM_PHYS = 64,
   localparam int TAG_W = $clog2(NUM_PHYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             clr_we,
   output logic [TAG_W-1:0] clr_idx,
   output logic             done
);
   import zrm_pkg::*;

   localparam logic [TAG_W-1:0] LAST_IDX = TAG_W'(NUM_PHYS - 1);

   walk_state_t      state_q;
   logic [TAG_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= WALK_CLEAR;
         idx_q   <= '0;
      end else if (state_q == WALK_CLEAR) begin
         if (idx_q == LAST_IDX) state_q <= WALK_IDLE;
         else                   idx_q   <= idx_q + 1'b1;
      end
   end

   assign clr_we  = (state_q == WALK_CLEAR);
   assign clr_idx = idx_q;
   assign done    = (state_q == WALK_IDLE);

   // R1: once finished, the walk never restarts without reset
   a_r1_done_sticks: assert property (@(posedge clk) disable iff (!rst_n) done |=> done);
endmodule

// File: rtl/zrm_phys_file.sv
module zrm_phys_file #(
   parameter int NUM_PHYS = 64,
   parameter int DATA_W   = 32,
   localparam int TAG_W = $clog2(NUM_PHYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_we,
   input  logic [TAG_W-1:0]  clr_idx,
   input  logic              clear_done,
   input  logic              wb_valid,
   input  logic [TAG_W-1:0]  wb_tag,
   input  logic [DATA_W-1:0] wb_data,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem [NUM_PHYS];
   logic              wr_en;
   logic [TAG_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_val;

   // Entry 0 is pinned: ordinary writebacks never land there.
   always_comb begin
      if (clr_we) begin
         wr_en  = 1'b1;
         wr_idx = clr_idx;
         wr_val = '0;
      end else begin
         wr_en  = clear_done && wb_valid && (wb_tag != '0);
         wr_idx = wb_tag;
         wr_val = wb_data;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_val;
   end

   assign rd_data = mem[rd_tag];

   // R6: the pinned entry reads zero at all times after the walk
   a_r6_pinned_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_done && rd_tag == '0) |-> rd_data == '0);
endmodule

// File: rtl/zrm_free_ring.sv
module zrm_free_ring #(
   parameter int NUM_LOGICAL = 32,
   parameter int NUM_PHYS    = 64,
   localparam int TAG_W   = $clog2(NUM_PHYS),
   localparam int DEPTH   = NUM_PHYS - NUM_LOGICAL,
   localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pop,
   output logic [TAG_W-1:0] head,
   input  logic             push,
   input  logic [TAG_W-1:0] push_tag,
   output logic             empty,
   output logic             full
);
   import zrm_pkg::*;

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic [TAG_W-1:0] slot_q [DEPTH];
   logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= TAG_W'(NUM_LOGICAL + i);
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         cnt_q    <= CNT_FULL;
      end else begin
         if (push) begin
            slot_q[wr_ptr_q] <= push_tag;
            wr_ptr_q <= PTR_W'(ring_next(int'(wr_ptr_q), DEPTH));
         end
         if (pop) rd_ptr_q <= PTR_W'(ring_next(int'(rd_ptr_q), DEPTH));
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign head  = slot_q[rd_ptr_q];
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNT_FULL);

   // R8: allocation never draws from an empty list
   a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
   // R7: the pinned tag never re-enters the list
   a_r7_no_zero_push: assert property (@(posedge clk) disable iff (!rst_n) push |-> push_tag != '0);
   // R7: releases never exceed the spare capacity
   a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n) (push && !pop) |-> !full);
endmodule

// File: rtl/zero_pinned_rename.sv
module zero_pinned_rename #(
   parameter int NUM_LOGICAL = 32,
   parameter int NUM_PHYS    = 64,
   parameter int DATA_W      = 32,
   localparam int LREG_W = $clog2(NUM_LOGICAL),
   localparam int TAG_W  = $clog2(NUM_PHYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              ready,
   input  logic              ren_valid,
   input  logic [LREG_W-1:0] ren_src_a,
   input  logic [LREG_W-1:0] ren_src_b,
   input  logic [LREG_W-1:0] ren_dst,
   input  logic              ren_wr,
   output logic              ren_grant,
   output logic [TAG_W-1:0]  ren_tag_a,
   output logic [TAG_W-1:0]  ren_tag_b,
   output logic [TAG_W-1:0]  ren_tag_dst,
   output logic [TAG_W-1:0]  ren_tag_old,
   output logic              ren_dst_we,
   input  logic              rel_valid,
   input  logic [TAG_W-1:0]  rel_tag,
   input  logic              wb_valid,
   input  logic [TAG_W-1:0]  wb_tag,
   input  logic [DATA_W-1:0] wb_data,
   input  logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   output logic              free_empty,
   output logic              free_full
);
   if (NUM_LOGICAL < 2 || (1 << LREG_W) != NUM_LOGICAL) begin : g_bad_logical
      $error("NUM_LOGICAL must be a power of two of at least 2");
   end
   if (NUM_PHYS <= NUM_LOGICAL) begin : g_bad_phys
      $error("NUM_PHYS must exceed NUM_LOGICAL");
   end

   logic [TAG_W-1:0] map_q [NUM_LOGICAL];
   logic             clr_we;
   logic [TAG_W-1:0] clr_idx;
   logic             dst_live;
   logic             alloc;
   logic             release_ok;
   logic [TAG_W-1:0] fl_head;

   zrm_zero_walker #(.NUM_PHYS(NUM_PHYS)) u_walker (
      .clk(clk), .rst_n(rst_n), .clr_we(clr_we), .clr_idx(clr_idx), .done(ready)
   );

   zrm_phys_file #(.NUM_PHYS(NUM_PHYS), .DATA_W(DATA_W)) u_file (
      .clk(clk), .rst_n(rst_n), .clr_we(clr_we), .clr_idx(clr_idx), .clear_done(ready),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
      .rd_tag(rd_tag), .rd_data(rd_data)
   );

   zrm_free_ring #(.NUM_LOGICAL(NUM_LOGICAL), .NUM_PHYS(NUM_PHYS)) u_ring (
      .clk(clk), .rst_n(rst_n), .pop(alloc), .head(fl_head),
      .push(release_ok), .push_tag(rel_tag), .empty(free_empty), .full(free_full)
   );

   // Decode-side clear of the write flag for destination 0
   assign dst_live    = ren_wr && (ren_dst != '0);
   assign ren_grant   = ready && ren_valid && (!dst_live || !free_empty);
   assign alloc       = ren_grant && dst_live;
   assign release_ok  = rel_valid && (rel_tag != '0);

   assign ren_tag_a   = map_q[ren_src_a];
   assign ren_tag_b   = map_q[ren_src_b];
   assign ren_tag_old = map_q[ren_dst];
   assign ren_tag_dst = dst_live ? fl_head : map_q[ren_dst];
   assign ren_dst_we  = dst_live;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_LOGICAL; i++) map_q[i] <= TAG_W'(i);
      end else if (alloc) begin
         map_q[ren_dst] <= fl_head;
      end
   end

   // R2: nothing is granted before the clearing walk ends
   a_r2_hold_off: assert property (@(posedge clk) disable iff (!rst_n) !ready |-> !ren_grant);
   // R4: destination 0 never carries a write flag or a live tag
   a_r4_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_dst == '0) |-> (!ren_dst_we && ren_tag_dst == '0 && ren_tag_old == '0));
   // R6: source index 0 always resolves to the pinned entry
   a_r6_src_pinned: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_src_a == '0) |-> ren_tag_a == '0);
   // R5: a granted write gets a tag other than the pinned one
   a_r5_fresh_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_grant && ren_dst_we) |-> ren_tag_dst != '0);
endmodule

// File: tb/zero_pinned_rename_test.sv
module zero_pinned_rename_test;
   localparam int NL = 32;
   localparam int NP = 64;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ready;
   logic          ren_valid, ren_wr, ren_grant, ren_dst_we;
   logic [4:0]    ren_src_a, ren_src_b, ren_dst;
   logic [5:0]    ren_tag_a, ren_tag_b, ren_tag_dst, ren_tag_old;
   logic          rel_valid, wb_valid;
   logic [5:0]    rel_tag, wb_tag, rd_tag;
   logic [DW-1:0] wb_data, rd_data;
   logic          free_empty, free_full;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   zero_pinned_rename #(.NUM_LOGICAL(NL), .NUM_PHYS(NP), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .ready(ready),
      .ren_valid(ren_valid), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
      .ren_dst(ren_dst), .ren_wr(ren_wr), .ren_grant(ren_grant),
      .ren_tag_a(ren_tag_a), .ren_tag_b(ren_tag_b), .ren_tag_dst(ren_tag_dst),
      .ren_tag_old(ren_tag_old), .ren_dst_we(ren_dst_we),
      .rel_valid(rel_valid), .rel_tag(rel_tag),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
      .rd_tag(rd_tag), .rd_data(rd_data),
      .free_empty(free_empty), .free_full(free_full)
   );

   // {src_a, src_b, dst, wr, exp_a, exp_b, exp_dst, exp_old, exp_we}
   localparam logic [40:0] VEC [7] = '{
      {5'd1,  5'd2, 5'd3,  1'b1, 6'd1,  6'd2,  6'd32, 6'd3,  1'b1},
      {5'd3,  5'd0, 5'd3,  1'b1, 6'd32, 6'd0,  6'd33, 6'd32, 1'b1},
      {5'd3,  5'd3, 5'd0,  1'b1, 6'd33, 6'd33, 6'd0,  6'd0,  1'b0},
      {5'd0,  5'd5, 5'd5,  1'b0, 6'd0,  6'd5,  6'd5,  6'd5,  1'b0},
      {5'd5,  5'd3, 5'd31, 1'b1, 6'd5,  6'd33, 6'd34, 6'd31, 1'b1},
      {5'd31, 5'd0, 5'd0,  1'b0, 6'd34, 6'd0,  6'd0,  6'd0,  1'b0},
      {5'd31, 5'd1, 5'd1,  1'b1, 6'd34, 6'd1,  6'd35, 6'd1,  1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; ren_valid = 0; ren_wr = 0; ren_src_a = 0; ren_src_b = 0; ren_dst = 0;
      rel_valid = 0; rel_tag = 0; wb_valid = 0; wb_tag = 0; wb_data = 0; rd_tag = 0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 ready in reset", ready, 0);
      chk("R3 free_full at reset", free_full, 1);
      chk("R3 free_empty at reset", free_empty, 0);
      // R2: request a write rename throughout the walk
      ren_valid = 1; ren_wr = 1; ren_dst = 3;
      rst_n = 1'b1;
      for (int k = 1; k < NP; k++) begin
         @(negedge clk); #1;
         chk("R1 ready low during walk", ready, 0);
         chk("R2 no grant during walk", ren_grant, 0);
      end
      ren_valid = 0;
      @(negedge clk); #1;
      chk("R1 ready after walk", ready, 1);
      chk("R3 free list untouched by held request", free_full, 1);
      // R1: every entry zero
      for (int t = 0; t < NP; t++) begin
         rd_tag = 6'(t); #1;
         chk("R1 entry cleared", rd_data, 0);
      end
      // R3: identity map
      for (int i = 0; i < NL; i++) begin
         ren_src_a = 5'(i); ren_src_b = 5'(NL - 1 - i); #1;
         chk("R3 identity map a", ren_tag_a, i);
         chk("R3 identity map b", ren_tag_b, NL - 1 - i);
      end
      // Vector table: R3 ordering, R4, R5, R6
      for (int v = 0; v < 7; v++) begin
         @(negedge clk);
         {ren_src_a, ren_src_b, ren_dst, ren_wr} = VEC[v][40:25];
         ren_valid = 1; #1;
         chk("R5 grant", ren_grant, 1);
         chk("R5 R6 src a tag", ren_tag_a, VEC[v][24:19]);
         chk("R5 R6 src b tag", ren_tag_b, VEC[v][18:13]);
         chk("R3 R4 R5 dst tag", ren_tag_dst, VEC[v][12:7]);
         chk("R4 R5 old tag", ren_tag_old, VEC[v][6:1]);
         chk("R4 write flag", ren_dst_we, VEC[v][0]);
      end
      @(negedge clk);
      ren_valid = 0;
      // R6 / R9: writebacks
      wb_valid = 1; wb_tag = 0; wb_data = 32'hDEAD;
      @(negedge clk);
      wb_tag = 32; wb_data = 32'h1234;
      @(negedge clk);
      wb_valid = 0;
      rd_tag = 0; #1;
      chk("R6 write to pinned entry dropped", rd_data, 0);
      rd_tag = 32; #1;
      chk("R9 writeback stored", rd_data, 32'h1234);
      // R7: release tag 3 then tag 0
      @(negedge clk);
      rel_valid = 1; rel_tag = 3;
      @(negedge clk);
      rel_tag = 0;
      @(negedge clk);
      rel_valid = 0;
      // Drain: 28 left from reset (36..63), then released 3
      for (int k = 0; k < 29; k++) begin
         ren_valid = 1; ren_wr = 1; ren_dst = 7; #1;
         chk("R8 grant while tags remain", ren_grant, 1);
         chk("R7 allocation order", ren_tag_dst, (k < 28) ? 36 + k : 3);
         @(negedge clk);
      end
      #1;
      chk("R7 R8 list empty after drain", free_empty, 1);
      chk("R8 write refused when empty", ren_grant, 0);
      ren_wr = 0; #1;
      chk("R8 non-write granted when empty", ren_grant, 1);
      ren_valid = 0; ren_src_a = 7; #1;
      chk("R5 map updated", ren_tag_a, 3);
      // Reset mid-run restores map and list
      @(negedge clk);
      rst_n = 0; #1;
      chk("R1 ready drops in reset", ready, 0);
      chk("R3 map restored", ren_tag_a, 7);
      chk("R3 list refilled", free_full, 1);
      @(negedge clk);
      rst_n = 1;
      repeat (NP) @(negedge clk);
      #1;
      chk("R1 ready after second walk", ready, 1);
      rd_tag = 32; #1;
      chk("R1 entry recleared", rd_data, 0);
      finish_run();
   end
endmodule